// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Chain

This block is a parameterised chain of polarity-hold scan cells for a level-sensitive scan design. Each cell holds two latches. The first latch, the master, takes system data while the system clock level is high. It takes scan data while scan phase one is high. The second latch, the slave, copies the master while scan phase two is high. The slave of each cell feeds the scan input of the next cell. The chain therefore forms a shift register from a scan-in pin to a scan-out pin, and it adds four pins to the design: the two scan phases, scan-in and scan-out.

The three latch clocks are treated as level inputs and sampled on a fast free-running clock `clk`. A level that is high in a sampling cycle makes the matching latch transparent for that cycle, and the new value appears at the outputs one `clk` cycle later. In normal use both scan phases stay low and the system clock level is pulsed. A following pulse on phase two makes the slave mirror the master, which gives master-slave behaviour for system paths.

For scan, the system clock level stays low and phase one and phase two are pulsed in turn. A monitor raises an error pulse when scan phase one overlaps either the system clock or scan phase two. The latches have no reset. Their contents are defined only after a load.

Top module: `lssd_chain`

## Requirements
- R1: In a cycle where `clk_c` is 1, every master latch takes its `sys_d` bit, and `l1_q` shows that value one `clk` cycle later.
- R2: In a cycle where both `clk_c` and `clk_a` are 0, `l1_q` keeps its value in the next cycle.
- R3: In a cycle where `clk_a` is 1 and `clk_c` is 0, master 0 takes `scan_in` and master i (i>0) takes the value of slave i-1 from that cycle.
- R4: In a cycle where `clk_b` is 1, `l2_q` takes the value `l1_q` had in that cycle. When `clk_b` is 0, `l2_q` holds.
- R5: `scan_out` always equals the slave of the last cell, `l2_q[N-1]`.
- R6: After N scan pairs (one `clk_a` pulse followed by one `clk_b` pulse), the bit applied to `scan_in` during pair k sits in slave N-1-k. Bit 0 therefore arrives at `scan_out`.
- R7: `clk_err` is 1 in the cycle after a cycle in which `clk_a` and `clk_c` were both 1, or `clk_a` and `clk_b` were both 1. Otherwise it is 0, and it is 0 during and right after reset.
- R8: When `clk_a` and `clk_c` are 1 together, system data wins: the master latches take `sys_d`.
- R9: A `clk_c` pulse followed by a `clk_b` pulse leaves `l2_q` equal to the captured `sys_d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the latch clock levels |
| rst_n | input | 1 | Active-low reset of the clock-rule monitor only |
| clk_c | input | 1 | System capture clock level |
| clk_a | input | 1 | Scan phase one level (master loads scan data) |
| clk_b | input | 1 | Scan phase two level (slave copies master) |
| sys_d | input | N | System data, one bit per cell |
| scan_in | input | 1 | Serial scan input to cell 0 |
| l1_q | output | N | Master latch contents |
| l2_q | output | N | Slave latch contents |
| scan_out | output | 1 | Serial scan output, slave of cell N-1 |
| clk_err | output | 1 | Clock overlap error pulse |

## Verification
A master latch holding a wrong value shows on `l1_q` in the cycle after the faulty load. It then reaches `l2_q` at the next `clk_b` pulse. A wrong link between cells corrupts scan data only at the cell where the link breaks, and `scan_out` shows that bit only after enough further shift pairs to carry it to the end of the chain. For this reason the bench compares the whole parallel state every cycle rather than relying on `scan_out` alone. A wrong overlap decision shows on `clk_err` exactly one cycle after the offending levels.

// File: rtl/lssd_pkg.sv
package lssd_pkg;

    typedef struct packed {
        logic mst;
        logic slv;
    } cell_state_t;

    typedef struct packed {
        logic err;
    } mon_state_t;

    function automatic logic clocks_collide(input logic c, input logic a, input logic b);
        return (a & c) | (a & b);
    endfunction

endpackage

// File: rtl/srl_cell.sv
module srl_cell
    import lssd_pkg::*;
(
    input  logic clk,
    input  logic lvl_c,
    input  logic lvl_a,
    input  logic lvl_b,
    input  logic sys_bit,
    input  logic scan_bit,
    output logic mst_o,
    output logic slv_o
);

    cell_state_t st_d;
    cell_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (lvl_c) begin
            st_d.mst = sys_bit;
        end else if (lvl_a) begin
            st_d.mst = scan_bit;
        end
        if (lvl_b) begin
            st_d.slv = st_q.mst;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mst_o = st_q.mst;
    assign slv_o = st_q.slv;

endmodule

// File: rtl/clk_rule_mon.sv
module clk_rule_mon
    import lssd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_c,
    input  logic lvl_a,
    input  logic lvl_b,
    output logic err_o
);

    mon_state_t mon_d;
    mon_state_t mon_q;

    always_comb begin
        mon_d     = mon_q;
        mon_d.err = clocks_collide(lvl_c, lvl_a, lvl_b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign err_o = mon_q.err;

endmodule

// File: rtl/lssd_chain.sv
module lssd_chain #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_c,
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic [N-1:0] sys_d,
    input  logic         scan_in,
    output logic [N-1:0] l1_q,
    output logic [N-1:0] l2_q,
    output logic         scan_out,
    output logic         clk_err
);

    localparam int LAST = N - 1;

    logic [N-1:0] scan_link;

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            if (i == 0) begin : g_head
                assign scan_link[i] = scan_in;
            end else begin : g_body
                assign scan_link[i] = l2_q[i-1];
            end

            srl_cell u_cell (
                .clk      (clk),
                .lvl_c    (clk_c),
                .lvl_a    (clk_a),
                .lvl_b    (clk_b),
                .sys_bit  (sys_d[i]),
                .scan_bit (scan_link[i]),
                .mst_o    (l1_q[i]),
                .slv_o    (l2_q[i])
            );
        end
    endgenerate

    assign scan_out = l2_q[LAST];

    clk_rule_mon u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_c (clk_c),
        .lvl_a (clk_a),
        .lvl_b (clk_b),
        .err_o (clk_err)
    );

endmodule

// File: rtl/lssd_chain_chk.sv
module lssd_chain_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_c,
    input logic         clk_a,
    input logic         clk_b,
    input logic [N-1:0] sys_d,
    input logic         scan_in,
    input logic [N-1:0] l1_q,
    input logic [N-1:0] l2_q,
    input logic         scan_out,
    input logic         clk_err
);

    p_sys_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_c |=> (l1_q == $past(sys_d)));

    p_mst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_c && !clk_a) |=> $stable(l1_q));

    p_scan_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_a && !clk_c) |=> (l1_q[0] == $past(scan_in)));

    p_slv_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_b |=> (l2_q == $past(l1_q)));

    p_slv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_b |=> $stable(l2_q));

    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_a && clk_c) || (clk_a && clk_b)) |=> clk_err);

    p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !((clk_a && clk_c) || (clk_a && clk_b)) |=> !clk_err);

    p_sys_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_a && clk_c) |=> (l1_q == $past(sys_d)));

endmodule

bind lssd_chain lssd_chain_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_c    (clk_c),
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .sys_d    (sys_d),
    .scan_in  (scan_in),
    .l1_q     (l1_q),
    .l2_q     (l2_q),
    .scan_out (scan_out),
    .clk_err  (clk_err)
);

// File: tb/lssd_chain_bench.sv
module lssd_chain_bench;

    localparam int N    = 8;
    localparam int HALF = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_c = 1'b0;
    logic         clk_a = 1'b0;
    logic         clk_b = 1'b0;
    logic [N-1:0] sys_d = '0;
    logic         scan_in = 1'b0;
    logic [N-1:0] l1_q;
    logic [N-1:0] l2_q;
    logic         scan_out;
    logic         clk_err;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [N-1:0] m_l1 = '0;
    logic [N-1:0] m_l2 = '0;
    logic         m_err = 1'b0;
    bit           l1_known = 1'b0;
    bit           l2_known = 1'b0;

    always #HALF clk = ~clk;

    lssd_chain #(.N(N)) u_lssd_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_c    (clk_c),
        .clk_a    (clk_a),
        .clk_b    (clk_b),
        .sys_d    (sys_d),
        .scan_in  (scan_in),
        .l1_q     (l1_q),
        .l2_q     (l2_q),
        .scan_out (scan_out),
        .clk_err  (clk_err)
    );

    function automatic logic [N-1:0] exp_master(input logic [N-1:0] cur, input logic [N-1:0] slv,
                                                 input logic c, input logic a,
                                                 input logic [N-1:0] d, input logic si);
        if (c) return d;
        if (a) return {slv[N-2:0], si};
        return cur;
    endfunction

    function automatic logic exp_collide(input logic c, input logic a, input logic b);
        return (a && c) || (a && b);
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic a, input logic b,
                        input logic [N-1:0] d, input logic si);
        logic [N-1:0] n_l1;
        logic [N-1:0] n_l2;
        string        r_l1;
        clk_c   = c;
        clk_a   = a;
        clk_b   = b;
        sys_d   = d;
        scan_in = si;
        n_l1  = exp_master(m_l1, m_l2, c, a, d, si);
        n_l2  = b ? m_l1 : m_l2;
        m_err = exp_collide(c, a, b);
        if (b) l2_known = l1_known;
        if (c) l1_known = 1'b1;
        m_l1 = n_l1;
        m_l2 = n_l2;
        r_l1 = (c && a) ? "R8" : (c ? "R1" : (a ? "R3" : "R2"));
        @(posedge clk);
        #2;
        if (l1_known) check(r_l1, l1_q, m_l1);
        if (l2_known) begin
            check("R4", l2_q, m_l2);
            check("R5", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, m_l2[N-1]});
        end
        check("R7", {{(N-1){1'b0}}, clk_err}, {{(N-1){1'b0}}, m_err});
        @(negedge clk);
    endtask

    initial begin
        #(2 * HALF * 200000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pat;
        void'($urandom(32'h1a5d));
        repeat (3) @(negedge clk);
        check("R7", {{(N-1){1'b0}}, clk_err}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: capture then mirror
        step(1, 0, 0, 8'hA5, 0);
        step(0, 0, 0, 8'h00, 0);
        step(0, 0, 1, 8'h3C, 0);
        check("R9", l2_q, 8'hA5);

        // R6: shift a pattern through N pairs
        pat = 8'b1011_0010;
        for (int k = 0; k < N; k++) begin
            step(0, 1, 0, 8'hFF, pat[k]);
            step(0, 0, 1, 8'hFF, 1'b0);
        end
        for (int k = 0; k < N; k++) begin
            check("R6", {{(N-1){1'b0}}, l2_q[N-1-k]}, {{(N-1){1'b0}}, pat[k]});
        end
        check("R6", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, pat[0]});

        // R8 and R7 corner: phase one with system clock, then phase overlap
        step(1, 1, 0, 8'h5A, 1);
        check("R8", l1_q, 8'h5A);
        step(0, 1, 1, 8'h00, 0);
        step(0, 0, 0, 8'h00, 0);
        // R2: idle hold
        step(0, 0, 0, 8'hC3, 1);

        for (int i = 0; i < 400; i++) begin
            logic [2:0] sel;
            sel = 3'($urandom_range(0, 7));
            case (sel)
                3'd0, 3'd1: step(1, 0, 0, N'($urandom), 1'($urandom));
                3'd2, 3'd3: step(0, 1, 0, N'($urandom), 1'($urandom));
                3'd4, 3'd5: step(0, 0, 1, N'($urandom), 1'($urandom));
                3'd6:       step(0, 0, 0, N'($urandom), 1'($urandom));
                default:    step(1'($urandom), 1'($urandom), 1'($urandom),
                                 N'($urandom), 1'($urandom));
            endcase
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule